// File: doc/BRIEF.md
# Sixteen-pin general-purpose I/O port with selective open-drain

This block is a 16-pin general-purpose I/O port, controlled through three memory-mapped registers on a plain 16-bit read/write bus. A direction register decides which pins drive. A data latch holds the values to drive. An open-drain register turns a few chosen pins from push-pull drivers into wired-OR drivers. Per pin, the block presents an output-enable and an output value to a tri-state pad. It also brings each pad's level back in through a two-flop sampler.

A read of the data register never returns the latch. It returns the sampled pin level. Software can therefore compare what it wrote with what is actually on the wire, and spot a pin that another driver overrides. Only pins 4 to 15 exist. Only pins 9, 12 and 14 can run as open-drain.

Bus bit numbering is big-endian: register bit k (with k = 0 as the most significant bit) sits at `bus_wdata[15-k]` and `bus_rdata[15-k]`. Register bit k controls pin k, and pin k is `pad_oe[k]`, `pad_out[k]` and `pad_in[k]`. Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_sel=1` with `bus_wr=0`, and it is zero at all other times. Writes take effect at the rising clock edge on which `bus_sel=1` and `bus_wr=1`.

Top module: `pio_port16`

## Requirements
- R1: The direction register sits at offset 0x950, the open-drain register at 0x954 and the data register at 0x956. A read from any other offset returns 0, and a write to any other offset changes no register.
- R2: Reset (`rst_n` low) clears the direction register and the open-drain register to 0. After reset every `pad_oe` bit is 0.
- R3: Only open-drain bits for pins 9, 12 and 14 are stored (bus mask 0x004A). Every other bit of that register reads 0 and ignores writes.
- R4: For an output pin (direction bit 1) whose open-drain bit is 0, `pad_oe` is 1 and `pad_out` equals the latched data bit.
- R5: For an output pin whose open-drain bit is 1, a latched 0 gives `pad_oe`=1 with `pad_out`=0, and a latched 1 gives `pad_oe`=0. The pin is never driven high.
- R6: A pin whose direction bit is 0 has `pad_oe`=0, whatever its data and open-drain bits hold.
- R7: A data register read returns the sampled level of each of pins 4 to 15, whatever the pin's direction. When an external driver overrides an output, the read shows the external level and not the written value.
- R8: A data register write is latched whatever the direction. The latched value reaches `pad_out` only while the pin is an output, and it is kept across direction changes.
- R9: Pins 0 to 3 do not exist. Their data and direction bits (bus mask 0xF000) read 0 and ignore writes, and their `pad_oe` is always 0.
- R10: A change on `pad_in` is visible in a data read after two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 16 | Write data, big-endian bit numbering |
| bus_rdata | output | 16 | Read data, zero when not reading |
| pad_in | input | 16 | Sampled pad level, pin k on bit k |
| pad_oe | output | 16 | Pad output enable, pin k on bit k |
| pad_out | output | 16 | Pad output value, pin k on bit k |

## Verification
The assertions assume that the bus strobes, the address and the write data are known and settled at every rising edge once reset has been released. The bench meets this by changing them only on falling edges and by holding `bus_sel` low when it is idle. The sampler check assumes `pad_in` carries known levels. The data latch powers up undefined, so the bench writes the data register before it makes any pin an output. The bench's pad model pulls undriven pins to 1 and lets an external driver override the port. This keeps every pad level defined while output conflicts are created on purpose.

// File: rtl/pio_port16.sv
module pio_port16 #(
  parameter int          W        = 16,
  parameter int          AW       = 12,
  parameter logic [11:0] DIR_OFS  = 12'h950,
  parameter logic [11:0] OD_OFS   = 12'h954,
  parameter logic [11:0] DAT_OFS  = 12'h956,
  parameter logic [15:0] OD_MASK  = 16'h004A,
  parameter logic [15:0] PIN_MASK = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out
);
  logic [W-1:0] dir_q, od_q, dat_q, sync1_q, sync_q;
  logic [W-1:0] dir_pin, od_pin, dat_pin, sync_bus;
  logic         wr_dir, wr_od, wr_dat, rd;

  assign rd     = bus_sel & ~bus_wr;
  assign wr_dir = bus_sel & bus_wr & (bus_addr == DIR_OFS);
  assign wr_od  = bus_sel & bus_wr & (bus_addr == OD_OFS);
  assign wr_dat = bus_sel & bus_wr & (bus_addr == DAT_OFS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      od_q  <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata & PIN_MASK;
      if (wr_od)  od_q  <= bus_wdata & OD_MASK;
    end

  always_ff @(posedge clk)
    if (wr_dat) dat_q <= bus_wdata & PIN_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync_q  <= sync1_q;
    end

  assign dir_pin  = {<<{dir_q}};
  assign od_pin   = {<<{od_q}};
  assign dat_pin  = {<<{dat_q}};
  assign sync_bus = {<<{sync_q}};

  assign pad_oe  = dir_pin & ~(od_pin & dat_pin);
  assign pad_out = dat_pin & ~od_pin & dir_pin;

  always_comb begin
    bus_rdata = '0;
    if (rd)
      case (bus_addr)
        DIR_OFS: bus_rdata = dir_q;
        OD_OFS:  bus_rdata = od_q;
        DAT_OFS: bus_rdata = sync_bus & PIN_MASK;
        default: bus_rdata = '0;
      endcase
  end
endmodule

module pio_port16_chk #(
  parameter int          W        = 16,
  parameter int          AW       = 12,
  parameter logic [11:0] DIR_OFS  = 12'h950,
  parameter logic [11:0] OD_OFS   = 12'h954,
  parameter logic [15:0] OD_MASK  = 16'h004A,
  parameter logic [15:0] PIN_MASK = 16'h0FFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  od_q,
  input logic [W-1:0]  sync_q
);
  logic [W-1:0] dir_rev, od_rev;
  logic [1:0]   cyc;
  assign dir_rev = {<<{dir_q}};
  assign od_rev  = {<<{od_q}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;

  AST_OD_MASK: assert property (@(posedge clk) disable iff (!rst_n) (od_q & ~OD_MASK) == '0); // R3
  AST_OD_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_sel && bus_wr && bus_addr == OD_OFS) |=> od_q == ($past(bus_wdata) & OD_MASK)); // R3
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_sel && bus_wr && bus_addr == DIR_OFS) |=> dir_q == ($past(bus_wdata) & PIN_MASK)); // R1
  AST_INPUT_NODRIVE: assert property (@(posedge clk) disable iff (!rst_n) (pad_oe & ~dir_rev) == '0); // R6
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (pad_oe & pad_out & od_rev) == '0); // R5
  AST_RSV_NODRIVE: assert property (@(posedge clk) disable iff (!rst_n) pad_oe[3:0] == 4'h0); // R9
  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n) (cyc == 2'd2) |-> sync_q == $past(pad_in, 2)); // R10
endmodule

bind pio_port16 pio_port16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_out(pad_out), .dir_q(dir_q), .od_q(od_q),
  .sync_q(sync_q)
);

// File: tb/sim_pio_port16.sv
`timescale 1ns/1ps
module sim_pio_port16;
  localparam logic [11:0] A_DIR = 12'h950, A_OD = 12'h954, A_DAT = 12'h956;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [15:0] pad_oe, pad_out, pad_in;
  logic [15:0] ext_en = '0, ext_val = '0;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  assign pad_in = (ext_en & ext_val) | (~ext_en & ((pad_oe & pad_out) | ~pad_oe));

  pio_port16 u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out));

  // {dir, od, dat, ext_en(pin order), ext_val(pin order), expected od readback}
  localparam int NV = 8;
  localparam logic [95:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0FFF, 16'h0000, 16'h0A5A, 16'h0000, 16'h0000, 16'h0000},
    {16'h0FFF, 16'hFFFF, 16'h0FFF, 16'h0000, 16'h0000, 16'h004A},
    {16'h0FFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h004A},
    {16'h0F0F, 16'h004A, 16'hF3C5, 16'h00F0, 16'h0050, 16'h004A},
    {16'h0000, 16'hFFB5, 16'hFFFF, 16'h0FFF, 16'h0123, 16'h0000},
    {16'h0FFF, 16'h0040, 16'h0FFF, 16'h0040, 16'h0000, 16'h0040},
    {16'h0ABC, 16'h0008, 16'h0555, 16'h000F, 16'h000A, 16'h0008}
  };

  function automatic logic [15:0] m_oe(logic [15:0] d, logic [15:0] o, logic [15:0] t);
    for (int n = 0; n < 16; n++) begin
      logic dd, oo, tt;
      dd = d[15-n] && n >= 4;
      oo = o[15-n] && (n == 9 || n == 12 || n == 14);
      tt = t[15-n] && n >= 4;
      m_oe[n] = dd && !(oo && tt);
    end
  endfunction

  function automatic logic [15:0] m_out(logic [15:0] o, logic [15:0] t);
    for (int n = 0; n < 16; n++)
      m_out[n] = t[15-n] && n >= 4 && !(o[15-n] && (n == 9 || n == 12 || n == 14));
  endfunction

  function automatic logic [15:0] m_rb(logic [15:0] oe, logic [15:0] out, logic [15:0] ee, logic [15:0] ev);
    for (int n = 0; n < 16; n++) begin
      logic lvl;
      lvl = ee[n] ? ev[n] : (oe[n] ? out[n] : 1'b1);
      m_rb[15-n] = (n >= 4) ? lvl : 1'b0;
    end
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] r, eoe, eout;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(A_DIR, r); check("R2 dir after reset", r, 16'h0000);
    rd(A_OD, r);  check("R2 od after reset", r, 16'h0000);
    check("R2 oe after reset", pad_oe, 16'h0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [15:0] vd, vo, vt, ve, vv, vx;
      {vd, vo, vt, ve, vv, vx} = VEC[i];
      wr(A_DAT, vt); wr(A_OD, vo); wr(A_DIR, vd);
      @(negedge clk); ext_en = ve; ext_val = vv;
      repeat (3) @(posedge clk);
      eoe = m_oe(vd, vo, vt);
      eout = m_out(vo, vt);
      rd(A_OD, r); check("R3 od readback", r, vx);
      check("R4 R5 R6 R9 oe", pad_oe, eoe);
      check("R4 R5 driven value", pad_out & pad_oe, eout & eoe);
      rd(A_DAT, r); check("R7 R9 data readback", r, m_rb(eoe, eout, ve, vv));
    end
    ext_en = '0;

    // unmapped offset
    wr(A_DIR, 16'h0123);
    wr(12'h952, 16'hFFFF);
    rd(12'h952, r); check("R1 unmapped read", r, 16'h0000);
    rd(A_DIR, r);   check("R1 unmapped write ignored", r, 16'h0123);

    // conflict: written 1, external 0 on pin 10
    wr(A_OD, 16'h0000); wr(A_DAT, 16'h0FFF); wr(A_DIR, 16'h0FFF);
    @(negedge clk); ext_en = 16'h0400; ext_val = 16'h0000;
    repeat (3) @(posedge clk);
    rd(A_DAT, r); check("R7 conflict visible", r, 16'h0FDF);
    ext_en = '0;

    // latch held while input, then appears
    wr(A_DIR, 16'h0000); wr(A_DAT, 16'h0800);
    check("R8 input pin not driven", pad_oe, 16'h0000);
    wr(A_DIR, 16'h0800);
    @(negedge clk);
    check("R8 latched value driven oe", pad_oe, 16'h0010);
    check("R8 latched value driven out", pad_out, 16'h0010);

    // reserved bits
    wr(A_DAT, 16'hFFFF); wr(A_DIR, 16'hFFFF);
    rd(A_DIR, r); check("R9 dir reserved bits", r, 16'h0FFF);
    check("R9 reserved pins undriven", pad_oe & 16'h000F, 16'h0000);
    check("R4 all outputs high", pad_out, 16'hFFF0);

    // sampler lag on pin 15 (bus bit 0): port drives 1, external forces 0
    @(negedge clk); ext_en = 16'h8000; ext_val = 16'h0000;
    @(posedge clk);
    rd(A_DAT, r); check("R10 one edge still old", r, 16'h0FFF);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = A_DAT; #1;
    check("R10 two edges new", bus_rdata, 16'h0FFE);
    bus_sel = 0;
    ext_en = '0;

    // reset clears od and dir
    wr(A_OD, 16'h004A);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(A_OD, r);  check("R2 od cleared by reset", r, 16'h0000);
    rd(A_DIR, r); check("R2 dir cleared by reset", r, 16'h0000);
    check("R2 R6 no drive after reset", pad_oe, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule